// File: doc/BRIEF.md
# PIO Sample Byte Sequencer

This block is the programmed-I/O data port of an audio codec's host interface. The host reaches it through one 8-bit register at address 3 of a 2-bit register address space. A read strobe at that address returns one byte of the current capture sample. A write strobe at that address stores one byte of the next playback sample. Two independent byte pointers keep track of where the host is in each sample. The capture pointer is exported as a status field, so software can tell which byte the next read will return.

The capture side takes a whole sample from the ADC side on a one-cycle strobe. The host then reads it out byte by byte. The pointer stops on the final byte until the next ADC sample arrives. The playback side collects bytes until a full sample is present, announces it to the DAC side with a one-cycle valid pulse, and drops further writes until the DAC side signals that it has taken the sample. The sample width follows two format inputs. While the codec is initialising, the port is locked.

Top module: `pio_byte_seq`

## Requirements
- R1: Read and write strobes with `reg_addr` other than 3 leave both pointers and both sample buffers unchanged.
- R2: The number of bytes per sample is 1 when `fmt_16bit`=0 and `fmt_stereo`=0. It is 2 when exactly one of the two is 1, and 4 when both are 1. `play_cnt` reaches exactly this count after a complete sample has been written.
- R3: `rd_data` is byte `cap_pos` of the capture sample, where byte k is `adc_sample[8k+7:8k]`. In 16-bit stereo the order is left low, left high, right low, right high. An accepted read advances `cap_pos` by one.
- R4: A read while `cap_pos` equals the byte count minus one leaves `cap_pos` unchanged.
- R5: `adc_stb` loads `adc_sample` into the capture buffer and sets `cap_pos` to 0 at the clock edge. It takes priority over a read in the same cycle, and that read returns the old byte.
- R6: While `init_busy` is 1, `rd_data` is 8'h80, reads do not advance `cap_pos`, and writes change neither `play_cnt` nor the playback buffer.
- R7: A write at `play_cnt`=k stores `wr_data` as byte k of the playback sample. The write that completes the sample makes `dac_valid` 1 for the next cycle. In that cycle `dac_sample` carries the sample, with all bytes beyond the byte count reading 0.
- R8: A write while `play_cnt` equals the byte count is ignored.
- R9: `dac_take` resets `play_cnt` to 0. An accepted write in the same cycle is stored as byte 0, leaving `play_cnt` at 1.
- R10: A synchronous active-low reset clears both pointers, both buffers and `dac_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address; 3 selects this port |
| rd_stb | input | 1 | One-cycle host read strobe |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_data | input | 8 | Playback byte from host |
| rd_data | output | 8 | Capture byte to host |
| init_busy | input | 1 | Codec initialising; port locked |
| fmt_stereo | input | 1 | 1 = two channels |
| fmt_16bit | input | 1 | 1 = 16-bit samples |
| adc_stb | input | 1 | New capture sample strobe |
| adc_sample | input | 32 | Capture sample |
| cap_pos | output | 2 | Byte the next capture read returns |
| dac_take | input | 1 | DAC side has taken the playback sample |
| dac_valid | output | 1 | One-cycle pulse: playback sample complete |
| dac_sample | output | 32 | Assembled playback sample |
| play_cnt | output | 3 | Playback bytes written so far |

## Verification
Two pairs of events can fall on the same edge. One pair is an ADC strobe and a host read. The other is a DAC take and a host write. The random stimulus raises each side independently, so both pairs coincide many times, and every format change forces a strobe and a take together. A reference model in the bench, written from the requirements, decides the result of each pair. After an ADC strobe the pointer must be 0 and the new sample visible. After a take with a write, the write must be byte 0 and `play_cnt` must be 1.

// File: rtl/pio_byte_seq.sv
module pio_byte_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        rd_stb,
  input  logic        wr_stb,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  input  logic        init_busy,
  input  logic        fmt_stereo,
  input  logic        fmt_16bit,
  input  logic        adc_stb,
  input  logic [31:0] adc_sample,
  output logic [1:0]  cap_pos,
  input  logic        dac_take,
  output logic        dac_valid,
  output logic [31:0] dac_sample,
  output logic [2:0]  play_cnt
);
  localparam logic [1:0] PORT_ADDR = 2'd3;

  logic [31:0] cap_buf, play_buf;
  logic [1:0]  cap_ptr;
  logic [2:0]  pcnt, base;
  logic [2:0]  nbytes;
  logic [1:0]  last;
  logic        sel, rd_ok, wr_ok;
  logic [31:0] mask;

  assign nbytes = (fmt_16bit & fmt_stereo) ? 3'd4 : (fmt_16bit | fmt_stereo) ? 3'd2 : 3'd1;
  assign last   = 2'(nbytes - 3'd1);
  assign mask   = (nbytes == 3'd4) ? 32'hFFFF_FFFF : (nbytes == 3'd2) ? 32'h0000_FFFF : 32'h0000_00FF;

  assign sel    = (reg_addr == PORT_ADDR) && !init_busy;
  assign rd_ok  = sel && rd_stb;
  assign base   = dac_take ? 3'd0 : pcnt;
  assign wr_ok  = sel && wr_stb && (base < nbytes);

  assign rd_data    = init_busy ? 8'h80 : cap_buf[cap_ptr*8 +: 8];
  assign cap_pos    = cap_ptr;
  assign play_cnt   = pcnt;
  assign dac_sample = play_buf & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_buf <= '0;
      cap_ptr <= '0;
    end else if (adc_stb) begin
      cap_buf <= adc_sample;
      cap_ptr <= '0;
    end else if (rd_ok && cap_ptr < last) begin
      cap_ptr <= cap_ptr + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      play_buf  <= '0;
      pcnt      <= '0;
      dac_valid <= 1'b0;
    end else begin
      dac_valid <= wr_ok && (base + 3'd1 == nbytes);
      if (wr_ok) begin
        play_buf[base[1:0]*8 +: 8] <= wr_data;
        pcnt <= base + 3'd1;
      end else begin
        pcnt <= base;
      end
    end
  end

  // R5
  cap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_stb |=> (cap_pos == 2'd0 && rd_data == (init_busy ? 8'h80 : $past(adc_sample[7:0]))));

  // R4
  cap_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && reg_addr == PORT_ADDR && cap_pos == last && !adc_stb) |=> $stable(cap_pos));

  // R6
  init_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_busy && !dac_take) |=> ($stable(play_cnt) && !dac_valid));

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (play_cnt == nbytes && !dac_take) |=> ($stable(play_cnt) && !dac_valid));

  // R9
  take_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_take |=> (play_cnt <= 3'd1));

  // R1
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != PORT_ADDR && !adc_stb && !dac_take) |=> ($stable(cap_pos) && $stable(play_cnt)));
endmodule

// File: tb/pio_byte_seq_bench.sv
`timescale 1ns/1ps
module pio_byte_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0]  wr_data = 8'd0;
  logic [7:0]  rd_data;
  logic        init_busy = 1'b0, fmt_stereo = 1'b0, fmt_16bit = 1'b0;
  logic        adc_stb = 1'b0;
  logic [31:0] adc_sample = 32'd0;
  logic [1:0]  cap_pos;
  logic        dac_take = 1'b0;
  logic        dac_valid;
  logic [31:0] dac_sample;
  logic [2:0]  play_cnt;

  pio_byte_seq u_pio_byte_seq (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_cbuf = 0, m_pbuf = 0;
  logic [2:0]  m_cptr = 0, m_pcnt = 0;
  bit m_valid = 0;
  bit p_adc = 0, p_take = 0, p_other = 0, p_init = 0;

  function automatic int nb_of(bit st, bit w16);
    return (st && w16) ? 4 : (st || w16) ? 2 : 1;
  endfunction

  function automatic logic [31:0] mask_of(int n);
    return (n == 4) ? 32'hFFFF_FFFF : (n == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    int n = nb_of(fmt_stereo, fmt_16bit);
    chk(init_busy ? "R6" : "R3", rd_data, init_busy ? 32'h80 : 32'(m_cbuf[m_cptr*8 +: 8]));
    chk(p_adc ? "R5" : (p_other ? "R1" : "R4"), cap_pos, m_cptr);
    chk(p_take ? "R9" : (p_init ? "R6" : (m_pcnt == n ? "R8" : "R2")), play_cnt, m_pcnt);
    chk("R7", dac_valid, m_valid);
    if (m_valid) chk("R7", dac_sample, m_pbuf & mask_of(n));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10
    chk("R10", rd_data, 0);
    chk("R10", cap_pos, 0);
    chk("R10", play_cnt, 0);
    chk("R10", dac_valid, 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      int n;
      bit rd_ok, wr_ok;
      int base;
      bit fmt_chg;
      fmt_chg   = ($urandom % 150) == 0;
      if (fmt_chg) begin
        fmt_stereo = $urandom % 2;
        fmt_16bit  = $urandom % 2;
      end
      reg_addr   = ($urandom % 10 < 7) ? 2'd3 : 2'($urandom % 3);
      rd_stb     = ($urandom % 10) < 4;
      wr_stb     = ($urandom % 10) < 4;
      wr_data    = 8'($urandom);
      init_busy  = ($urandom % 20) == 0;
      adc_stb    = fmt_chg || (($urandom % 12) == 0);
      adc_sample = $urandom;
      dac_take   = fmt_chg || (($urandom % 10) == 0);
      #1;
      check_outputs();
      n = nb_of(fmt_stereo, fmt_16bit);
      rd_ok = rd_stb && reg_addr == 3 && !init_busy;
      if (adc_stb) begin
        m_cbuf = adc_sample;
        m_cptr = 0;
      end else if (rd_ok && m_cptr < n - 1) m_cptr = m_cptr + 1;
      base = dac_take ? 0 : m_pcnt;
      wr_ok = wr_stb && reg_addr == 3 && !init_busy && base < n;
      if (wr_ok) begin
        m_pbuf[base*8 +: 8] = wr_data;
        m_pcnt = 3'(base + 1);
      end else m_pcnt = 3'(base);
      m_valid = wr_ok && (base + 1 == n);
      p_adc   = adc_stb;
      p_take  = dac_take;
      p_other = reg_addr != 3 && (rd_stb || wr_stb);
      p_init  = init_busy && wr_stb;
      @(negedge clk);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule